// File: doc/BRIEF.md
# Latched BCD Seven-Segment Decoder

This block turns a four-bit decimal digit code into the seven active-high drives of a seven-segment display. A holding register follows the input code while the latch-enable input is low. It keeps the last captured code while latch enable is high, so the display stays steady when the code bus is shared or changing.

Two active-low override inputs sit after the decoder. Lamp test lights every segment. Blanking darkens every segment unless lamp test is asserted at the same time. Codes above nine have no glyph and leave the display dark. The overrides act on the outputs only, so the held digit shows again as soon as both are released.

Top module: `bcd7_display`

## Requirements
- R1: While rst_n is 0 and for as long as no code is loaded afterwards, the held code is 0, so with lt_n=1 and bl_n=1 the output seg is 7'h3F.
- R2: On each rising clk edge with le=0, the register captures code_in. The matching glyph is on seg right after that edge. code_in bit 0 is the least significant bit and bit 3 the most significant.
- R3: While le=1, clock edges leave the held code unchanged, and changes on code_in have no effect on seg.
- R4: With lt_n=1 and bl_n=1, seg is ordered {g,f,e,d,c,b,a}, with a in bit 0. The held codes give these values: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 7=07, 8=7F.
- R5: Digit 6 is shown without segment a (seg=7'h7C), and digit 9 is shown without segment d (seg=7'h67).
- R6: With lt_n=1 and bl_n=1, held codes 10 to 15 give seg=7'h00.
- R7: When lt_n=0, seg=7'h7F whatever the values of bl_n, le, code_in and the held code.
- R8: When lt_n=1 and bl_n=0, seg=7'h00 for every held code.
- R9: lt_n and bl_n do not change the held code. After both return to 1, seg again shows the glyph of the code held before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the holding register |
| rst_n | input | 1 | Asynchronous active-low reset; clears the held code to 0 |
| code_in | input | 4 | Digit code, bit 0 least significant |
| le | input | 1 | 0: load code_in at each edge; 1: keep the held code |
| lt_n | input | 1 | Active-low lamp test, lights all segments |
| bl_n | input | 1 | Active-low blanking, darkens all segments unless lamp test is active |
| seg | output | 7 | Segment drives {g,f,e,d,c,b,a}, 1 lights a segment |

## Verification
The checker assumes that the inputs are stable around each rising clock edge, and that the override inputs are settled when it samples the combinational output at the edge. The bench keeps to this by changing every input on the falling clock edge and sampling a short time after the change. The hold and load properties assume that code_in carries no X or Z while le is low. The bench always drives a defined code before it releases reset.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_N  = 7;
  localparam int MAX_DIGIT = 9;

  typedef logic [SEG_N-1:0]  seg_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam seg_t SEG_ALL  = {SEG_N{1'b1}};
  localparam seg_t SEG_NONE = {SEG_N{1'b0}};

  // Glyph for a decimal digit, word ordered {g,f,e,d,c,b,a}
  function automatic seg_t glyph_of(input code_t c);
    seg_t s;
    case (c)
      4'd0: s = 7'b0111111;
      4'd1: s = 7'b0000110;
      4'd2: s = 7'b1011011;
      4'd3: s = 7'b1001111;
      4'd4: s = 7'b1100110;
      4'd5: s = 7'b1101101;
      4'd6: s = 7'b1111100;
      4'd7: s = 7'b0000111;
      4'd8: s = 7'b1111111;
      4'd9: s = 7'b1100111;
      default: s = SEG_NONE;
    endcase
    return s;
  endfunction

  function automatic logic digit_ok(input code_t c);
    return (c <= code_t'(MAX_DIGIT));
  endfunction
endpackage

// File: rtl/segdec_hold.sv
module segdec_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (!le) q <= d;
  end
endmodule

// File: rtl/segdec_glyph.sv
module segdec_glyph
  import segdec_pkg::*;
(
  input  code_t code,
  output logic  valid,
  output seg_t  glyph
);
  seg_t raw;
  always_comb begin
    raw   = glyph_of(code);
    valid = digit_ok(code);
    glyph = valid ? raw : SEG_NONE;
  end
endmodule

// File: rtl/segdec_override.sv
module segdec_override
  import segdec_pkg::*;
(
  input  seg_t glyph,
  input  logic lt_n,
  input  logic bl_n,
  output seg_t seg
);
  genvar i;
  generate
    for (i = 0; i < SEG_N; i++) begin : g_seg
      assign seg[i] = !lt_n | (bl_n & glyph[i]);
    end
  endgenerate
endmodule

// File: rtl/bcd7_display.sv
module bcd7_display
  import segdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic              le,
  input  logic              lt_n,
  input  logic              bl_n,
  output logic [SEG_N-1:0]  seg
);
  code_t held_code;
  logic  code_valid;
  seg_t  glyph_raw;

  segdec_hold #(.W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .le(le), .d(code_in), .q(held_code)
  );

  segdec_glyph u_glyph (
    .code(held_code), .valid(code_valid), .glyph(glyph_raw)
  );

  segdec_override u_ovr (
    .glyph(glyph_raw), .lt_n(lt_n), .bl_n(bl_n), .seg(seg)
  );
endmodule

// File: rtl/segdec_checker.sv
module segdec_checker
  import segdec_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input code_t code_in,
  input logic  le,
  input logic  lt_n,
  input logic  bl_n,
  input seg_t  seg,
  input code_t held,
  input logic  valid
);
  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> held == '0); // R1
  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> held == $past(code_in)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> $stable(held)); // R3
  AST_HIGH_CODE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_n && bl_n && !valid) |-> seg == SEG_NONE); // R6
  AST_LAMP_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !lt_n |-> seg == SEG_ALL); // R7
  AST_BLANK_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_n && !bl_n) |-> seg == SEG_NONE); // R8
endmodule

bind bcd7_display segdec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .code_in(code_in), .le(le), .lt_n(lt_n),
  .bl_n(bl_n), .seg(seg), .held(held_code), .valid(code_valid)
);

// File: tb/tb_bcd7_display.sv
module tb_bcd7_display;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] SA = 7'h01, SB = 7'h02, SC = 7'h04, SD = 7'h08,
                         SE = 7'h10, SF = 7'h20, SG = 7'h40;

  logic clk = 1'b0;
  logic rst_n, le, lt_n, bl_n;
  logic [3:0] code_in;
  logic [6:0] seg;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd7_display dut (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .le(le),
    .lt_n(lt_n), .bl_n(bl_n), .seg(seg)
  );

  function automatic logic [6:0] ref_seg(input int code, input logic lt, input logic bl);
    logic [6:0] s;
    case (code)
      0: s = SA | SB | SC | SD | SE | SF;
      1: s = SB | SC;
      2: s = SA | SB | SD | SE | SG;
      3: s = SA | SB | SC | SD | SG;
      4: s = SB | SC | SF | SG;
      5: s = SA | SC | SD | SF | SG;
      6: s = SC | SD | SE | SF | SG;
      7: s = SA | SB | SC;
      8: s = SA | SB | SC | SD | SE | SF | SG;
      9: s = SA | SB | SC | SF | SG;
      default: s = 7'h00;
    endcase
    if (!lt) s = 7'h7F;
    else if (!bl) s = 7'h00;
    return s;
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    n_chk++;
    if (seg !== exp) begin
      n_bad++;
      $display("FAIL %s seg actual=%h expected=%h", req, seg, exp);
    end
  endtask

  task automatic load(input int code);
    @(negedge clk);
    code_in = 4'(code); le = 1'b0;
    @(negedge clk);
    le = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; le = 1'b1; lt_n = 1'b1; bl_n = 1'b1; code_in = 4'd9;
    repeat (2) @(negedge clk);
    #1 check("R1 in reset", 7'h3F);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 check("R1 after reset", 7'h3F);
  endtask

  task automatic t_all_codes();
    for (int c = 0; c < 16; c++) begin
      load(c);
      for (int m = 0; m < 4; m++) begin
        lt_n = m[1]; bl_n = m[0];
        #1;
        if (m == 3)
          check(c > 9 ? "R6 high code" : ((c == 6 || c == 9) ? "R5 tail-less" : "R2 R4 glyph"),
                ref_seg(c, 1'b1, 1'b1));
        else if (m < 2) check("R7 lamp test", 7'h7F);
        else check("R8 blanking", 7'h00);
      end
      lt_n = 1'b1; bl_n = 1'b1;
    end
  endtask

  task automatic t_hold();
    load(3);
    for (int k = 0; k < 6; k++) begin
      code_in = 4'(k * 3 + 1);
      @(negedge clk); #1;
      check("R3 hold", 7'h4F);
    end
    // continuous load without le pulse
    @(negedge clk); code_in = 4'd8; le = 1'b0;
    #1 check("R2 no edge yet", 7'h4F);
    @(negedge clk); #1 check("R2 after edge", 7'h7F);
    code_in = 4'd1;
    @(negedge clk); #1 check("R2 follows", 7'h06);
    le = 1'b1;
  endtask

  task automatic t_restore();
    load(5);
    lt_n = 1'b0; code_in = 4'd2;
    @(negedge clk); #1 check("R7 lamp with hold", 7'h7F);
    lt_n = 1'b1; bl_n = 1'b0;
    @(negedge clk); #1 check("R8 blank with hold", 7'h00);
    bl_n = 1'b1;
    #1 check("R9 restore", 7'h6D);
    // overrides while loading still store the code
    @(negedge clk); bl_n = 1'b0; code_in = 4'd4; le = 1'b0;
    @(negedge clk); le = 1'b1; #1 check("R8 blank during load", 7'h00);
    bl_n = 1'b1; #1 check("R9 code loaded under blank", 7'h66);
  endtask

  initial begin
    t_reset();
    t_all_codes();
    t_hold();
    t_restore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule